// File: doc/BRIEF.md
# Paged Register Access Sequencer

This block turns a single 32-bit register access into a chain of 16-bit management transactions. The target device exposes its wide registers through a small window. First a page number goes into a dedicated page-select register. Then the lower half of the word is moved through a window register picked by a few low address bits. Last, the upper half is moved through a fixed data-high register. The host presents a byte address, a direction flag and, for a write, a 32-bit data word. The block then runs the three steps one at a time on a 16-bit request/response management port.

Every transaction goes to the device address given on a configuration input. That value is sampled when the request is accepted, so strap-dependent placements work without changes to the sequencer. A read returns the two halves joined into one word. If any step is answered with an error, the steps that remain are dropped and the request finishes with its error flag set.

Top module: `paged_reg_seq`

## Requirements
- R1: `req_ready` is high only when the block is idle. A request is taken on a cycle with `req_valid` and `req_ready` both high. While busy, `req_valid` has no effect: no extra transaction is issued and the running request is not disturbed.
- R2: The first transaction of every request is a write of the page number, byte-address bits [15:6] zero-extended to 16 bits, to management register 31.
- R3: The window register number is byte-address bits [5:2], zero-extended to 5 bits. Address bits [1:0] and [31:16] change neither the transactions nor the result.
- R4: A write request issues, in this order, the page write to register 31, a write of data bits [15:0] to the window register, and a write of data bits [31:16] to register 16.
- R5: A read request issues the page write to register 31, then a read of the window register, then a read of register 16. The result is `{data_from_reg16, data_from_window}`. Read transactions drive `mg_wdata` as zero.
- R6: Every transaction carries the device address that `cfg_phy_addr` held in the accepting cycle, even if the input changes later.
- R7: A transaction holds `mg_valid` and all its fields steady until `mg_ready`. After acceptance, the next transaction starts only after `mg_rsp_valid` has returned for the previous one.
- R8: A response with `mg_rsp_err` high ends the request at once. No further step is issued, `rsp_err` is 1 and `rsp_rdata` is 0 when done is signalled.
- R9: Each request produces exactly one `rsp_done` pulse, one cycle wide, in the cycle after its last response. On success `rsp_err` is 0, and `rsp_rdata` is 0 for a write. Both outputs hold their values until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_phy_addr | input | 5 | Management device address used for the next request |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | 32 | Byte address of the 32-bit register |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read data |
| rsp_err | output | 1 | Request ended with an error |
| mg_valid | output | 1 | Management transaction present |
| mg_ready | input | 1 | Management port accepts the transaction |
| mg_phy | output | 5 | Device address of the transaction |
| mg_reg | output | 5 | Register number of the transaction |
| mg_write | output | 1 | 1 = write transaction, 0 = read |
| mg_wdata | output | 16 | Transaction write data |
| mg_rsp_valid | input | 1 | Response for the accepted transaction |
| mg_rsp_data | input | 16 | Read data of the response |
| mg_rsp_err | input | 1 | Transaction failed |

## Verification
The bench places errors on the first, middle and last step. A design that went on after a failure would issue an extra transaction that the scoreboard does not expect, and one that dropped the flag would return a clean result. Addresses with the low two bits and the upper half set, plus the all-ones page and window, expose field extraction off by a bit or not masked: such a design would write a wrong page or pick a wrong window. The configuration address is changed right after acceptance and junk requests are pulsed while busy, which catches a design that samples the address late or restarts mid-sequence. Varying the ready and response latencies catches a design that moves to the next step before the response arrives, or that swaps the two halves of a read.

// File: rtl/paged_seq_pkg.sv
package paged_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_e;

    // Step order is behaviour: page select, window half, fixed high half.
    typedef enum logic [1:0] {
        STEP_PAGE = 2'd0,
        STEP_LOW  = 2'd1,
        STEP_HIGH = 2'd2
    } seq_step_e;

endpackage

// File: rtl/paged_seq_fields.sv
module paged_seq_fields #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_LSB   = 6,
    parameter int PAGE_W     = 10,
    parameter int LOWREG_LSB = 2,
    parameter int LOWREG_W   = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [PAGE_W-1:0]   page,
    output logic [LOWREG_W-1:0] low_reg
);
    localparam int PAGE_MSB = PAGE_LSB + PAGE_W - 1;

    // Bits outside both fields carry no meaning for the sequence.
    logic unused_addr_bits;

    assign page    = addr[PAGE_MSB:PAGE_LSB];
    assign low_reg = addr[LOWREG_LSB +: LOWREG_W];
    assign unused_addr_bits = ^{addr[ADDR_W-1:PAGE_MSB+1], addr[LOWREG_LSB-1:0]};

endmodule

// File: rtl/paged_seq_step.sv
module paged_seq_step
    import paged_seq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int REG_W    = 5,
    parameter int PAGE_W   = 10,
    parameter int LOWREG_W = 4,
    parameter int PAGE_REG = 31,
    parameter int HIGH_REG = 16
) (
    input  seq_step_e             step,
    input  logic                  is_write,
    input  logic [PAGE_W-1:0]     page,
    input  logic [LOWREG_W-1:0]   low_reg,
    input  logic [DATA_W-1:0]     wdata,
    output logic [REG_W-1:0]      reg_num,
    output logic                  wr,
    output logic [DATA_W/2-1:0]   data
);
    localparam int HALF_W = DATA_W / 2;

    always_comb begin
        case (step)
            STEP_PAGE: begin
                reg_num = REG_W'(PAGE_REG);
                wr      = 1'b1;
                data    = HALF_W'(page);
            end
            STEP_LOW: begin
                reg_num = REG_W'(low_reg);
                wr      = is_write;
                data    = is_write ? wdata[HALF_W-1:0] : '0;
            end
            default: begin
                reg_num = REG_W'(HIGH_REG);
                wr      = is_write;
                data    = is_write ? wdata[DATA_W-1:HALF_W] : '0;
            end
        endcase
    end

endmodule

// File: rtl/paged_reg_seq.sv
module paged_reg_seq
    import paged_seq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int PHY_W      = 5,
    parameter int REG_W      = 5,
    parameter int PAGE_LSB   = 6,
    parameter int PAGE_W     = 10,
    parameter int LOWREG_LSB = 2,
    parameter int LOWREG_W   = 4,
    parameter int PAGE_REG   = 31,
    parameter int HIGH_REG   = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PHY_W-1:0]     cfg_phy_addr,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 rsp_done,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 rsp_err,
    output logic                 mg_valid,
    input  logic                 mg_ready,
    output logic [PHY_W-1:0]     mg_phy,
    output logic [REG_W-1:0]     mg_reg,
    output logic                 mg_write,
    output logic [DATA_W/2-1:0]  mg_wdata,
    input  logic                 mg_rsp_valid,
    input  logic [DATA_W/2-1:0]  mg_rsp_data,
    input  logic                 mg_rsp_err
);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        seq_state_e            state;
        seq_step_e             step;
        logic                  is_write;
        logic [PHY_W-1:0]      phy;
        logic [PAGE_W-1:0]     page;
        logic [LOWREG_W-1:0]   low_reg;
        logic [DATA_W-1:0]     wdata;
        logic [DATA_W-1:0]     rdata;
        logic                  done;
        logic                  err;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic [PAGE_W-1:0]   dec_page;
    logic [LOWREG_W-1:0] dec_low;

    paged_seq_fields #(
        .ADDR_W     (ADDR_W),
        .PAGE_LSB   (PAGE_LSB),
        .PAGE_W     (PAGE_W),
        .LOWREG_LSB (LOWREG_LSB),
        .LOWREG_W   (LOWREG_W)
    ) u_fields (
        .addr    (req_addr),
        .page    (dec_page),
        .low_reg (dec_low)
    );

    paged_seq_step #(
        .DATA_W   (DATA_W),
        .REG_W    (REG_W),
        .PAGE_W   (PAGE_W),
        .LOWREG_W (LOWREG_W),
        .PAGE_REG (PAGE_REG),
        .HIGH_REG (HIGH_REG)
    ) u_step (
        .step     (seq_q.step),
        .is_write (seq_q.is_write),
        .page     (seq_q.page),
        .low_reg  (seq_q.low_reg),
        .wdata    (seq_q.wdata),
        .reg_num  (mg_reg),
        .wr       (mg_write),
        .data     (mg_wdata)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        case (seq_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    seq_d.state    = ST_ISSUE;
                    seq_d.step     = STEP_PAGE;
                    seq_d.is_write = req_write;
                    seq_d.phy      = cfg_phy_addr;
                    seq_d.page     = dec_page;
                    seq_d.low_reg  = dec_low;
                    seq_d.wdata    = req_wdata;
                    seq_d.rdata    = '0;
                    seq_d.err      = 1'b0;
                end
            end
            ST_ISSUE: begin
                if (mg_ready) begin
                    seq_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mg_rsp_valid) begin
                    if (mg_rsp_err) begin
                        seq_d.state = ST_IDLE;
                        seq_d.done  = 1'b1;
                        seq_d.err   = 1'b1;
                        seq_d.rdata = '0;
                    end else begin
                        if (!seq_q.is_write && seq_q.step == STEP_LOW) begin
                            seq_d.rdata[HALF_W-1:0] = mg_rsp_data;
                        end
                        if (!seq_q.is_write && seq_q.step == STEP_HIGH) begin
                            seq_d.rdata[DATA_W-1:HALF_W] = mg_rsp_data;
                        end
                        if (seq_q.step == STEP_HIGH) begin
                            seq_d.state = ST_IDLE;
                            seq_d.done  = 1'b1;
                        end else begin
                            seq_d.state = ST_ISSUE;
                            seq_d.step  = seq_step_e'(seq_q.step + 2'd1);
                        end
                    end
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.state == ST_IDLE);
    assign mg_valid  = (seq_q.state == ST_ISSUE);
    assign mg_phy    = seq_q.phy;
    assign rsp_done  = seq_q.done;
    assign rsp_rdata = seq_q.rdata;
    assign rsp_err   = seq_q.err;

endmodule

// File: rtl/paged_reg_seq_chk.sv
module paged_reg_seq_chk #(
    parameter int DATA_W   = 32,
    parameter int PHY_W    = 5,
    parameter int REG_W    = 5,
    parameter int PAGE_REG = 31
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                rsp_done,
    input logic [DATA_W-1:0]   rsp_rdata,
    input logic                rsp_err,
    input logic                mg_valid,
    input logic                mg_ready,
    input logic [PHY_W-1:0]    mg_phy,
    input logic [REG_W-1:0]    mg_reg,
    input logic                mg_write,
    input logic [DATA_W/2-1:0] mg_wdata
);

    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    assert_no_issue_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mg_valid |-> !req_ready);

    assert_page_is_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mg_valid && (mg_reg == REG_W'(PAGE_REG)) |-> mg_write);

    assert_hold_until_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mg_valid && !mg_ready |=> mg_valid && $stable(mg_reg) && $stable(mg_phy)
                                 && $stable(mg_write) && $stable(mg_wdata));

    assert_wait_response_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mg_valid && mg_ready |=> !mg_valid);

    assert_err_clears_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done && rsp_err |-> rsp_rdata == '0);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    assert_done_back_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready && !mg_valid);

endmodule

bind paged_reg_seq paged_reg_seq_chk #(
    .DATA_W   (DATA_W),
    .PHY_W    (PHY_W),
    .REG_W    (REG_W),
    .PAGE_REG (PAGE_REG)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err),
    .mg_valid  (mg_valid),
    .mg_ready  (mg_ready),
    .mg_phy    (mg_phy),
    .mg_reg    (mg_reg),
    .mg_write  (mg_write),
    .mg_wdata  (mg_wdata)
);

// File: tb/paged_reg_seq_bench.sv
`timescale 1ns/1ps
module paged_reg_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_phy_addr = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        mg_valid;
    logic        mg_ready = 1'b0;
    logic [4:0]  mg_phy;
    logic [4:0]  mg_reg;
    logic        mg_write;
    logic [15:0] mg_wdata;
    logic        mg_rsp_valid = 1'b0;
    logic [15:0] mg_rsp_data = '0;
    logic        mg_rsp_err = 1'b0;

    always #2 clk = ~clk;

    paged_reg_seq u_paged_reg_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_phy_addr (cfg_phy_addr),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_write    (req_write),
        .req_wdata    (req_wdata),
        .rsp_done     (rsp_done),
        .rsp_rdata    (rsp_rdata),
        .rsp_err      (rsp_err),
        .mg_valid     (mg_valid),
        .mg_ready     (mg_ready),
        .mg_phy       (mg_phy),
        .mg_reg       (mg_reg),
        .mg_write     (mg_write),
        .mg_wdata     (mg_wdata),
        .mg_rsp_valid (mg_rsp_valid),
        .mg_rsp_data  (mg_rsp_data),
        .mg_rsp_err   (mg_rsp_err)
    );

    typedef struct {
        logic [4:0]  phy;
        logic [4:0]  rg;
        logic        wr;
        logic [15:0] data;
    } txn_t;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
    } res_t;

    txn_t  exp_txn[$];
    res_t  exp_res[$];
    int    checks = 0;
    int    failures = 0;
    int    err_at = -1;
    int    resp_idx = 0;
    int    txn_count = 0;
    logic [9:0] last_page = '0;
    string cur_tag = "";
    bit    finished = 1'b0;

    function automatic logic [15:0] dev_val(input logic [4:0] phy,
                                            input logic [9:0] pg,
                                            input logic [4:0] rg);
        return 16'hA5C3 ^ {phy, rg, 6'b0} ^ {6'b0, pg};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // Management port model and transaction monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mg_valid) begin
                txn_t got;
                bit   inject;
                repeat (txn_count % 3) @(negedge clk);
                got = '{mg_phy, mg_reg, mg_write, mg_wdata};
                mg_ready = 1'b1;
                if (exp_txn.size() == 0) begin
                    check(1'b0, {cur_tag, " R8 unexpected transaction"},
                          {11'b0, got.phy, got.rg, got.data}, 32'h0);
                end else begin
                    txn_t e;
                    e = exp_txn.pop_front();
                    check(got.phy == e.phy, {cur_tag, " R6 device address"},
                          32'(got.phy), 32'(e.phy));
                    check(got.rg == e.rg && got.wr == e.wr,
                          {cur_tag, " R4 R5 register and direction"},
                          {26'b0, got.wr, got.rg}, {26'b0, e.wr, e.rg});
                    check(got.data == e.data, {cur_tag, " R2 R4 write data"},
                          32'(got.data), 32'(e.data));
                end
                if (got.wr && got.rg == 5'd31) last_page = got.data[9:0];
                inject = (resp_idx == err_at);
                resp_idx++;
                @(negedge clk);
                mg_ready = 1'b0;
                repeat (txn_count % 2) @(negedge clk);
                txn_count++;
                mg_rsp_valid = 1'b1;
                mg_rsp_err   = inject;
                mg_rsp_data  = got.wr ? 16'hDEAD : dev_val(got.phy, last_page, got.rg);
                @(negedge clk);
                mg_rsp_valid = 1'b0;
                mg_rsp_err   = 1'b0;
            end
        end
    end

    // Result monitor.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rsp_done) begin
                if (exp_res.size() == 0) begin
                    check(1'b0, {cur_tag, " R9 unexpected done"}, 32'h1, 32'h0);
                end else begin
                    res_t e;
                    e = exp_res.pop_front();
                    check(rsp_err == e.err, {cur_tag, " R8 R9 error flag"},
                          32'(rsp_err), 32'(e.err));
                    check(rsp_rdata == e.rdata, {cur_tag, " R5 R8 read data"},
                          rsp_rdata, e.rdata);
                end
                @(negedge clk);
                check(!rsp_done, {cur_tag, " R9 done one cycle"}, 32'(rsp_done), 32'h0);
            end
        end
    end

    task automatic do_req(input logic [31:0] addr, input logic wr,
                          input logic [31:0] wd, input logic [4:0] phy,
                          input int err_step, input string tag);
        logic [9:0] pg;
        logic [4:0] lo;
        txn_t t;
        res_t r;
        pg = addr[15:6];
        lo = {1'b0, addr[5:2]};
        t = '{phy, 5'd31, 1'b1, {6'b0, pg}};
        exp_txn.push_back(t);
        if (err_step != 0) begin
            t = '{phy, lo, wr, wr ? wd[15:0] : 16'h0};
            exp_txn.push_back(t);
        end
        if (err_step != 0 && err_step != 1) begin
            t = '{phy, 5'd16, wr, wr ? wd[31:16] : 16'h0};
            exp_txn.push_back(t);
        end
        r.err   = (err_step >= 0);
        r.rdata = (err_step >= 0 || wr) ? 32'h0
                  : {dev_val(phy, pg, 5'd16), dev_val(phy, pg, lo)};
        exp_res.push_back(r);
        cur_tag  = tag;
        err_at   = err_step;
        resp_idx = 0;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cfg_phy_addr = phy;
        req_addr     = addr;
        req_write    = wr;
        req_wdata    = wd;
        req_valid    = 1'b1;
        @(negedge clk);
        req_valid    = 1'b0;
        cfg_phy_addr = ~phy;
        @(negedge clk);
        // R1: a request while busy must be ignored
        req_valid = 1'b1;
        req_addr  = 32'hFFFF_FFFF;
        req_write = ~wr;
        check(!req_ready, {tag, " R1 busy"}, 32'(req_ready), 32'h0);
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_res.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        check(exp_txn.size() == 0, {tag, " R7 R8 all steps seen"},
              32'(exp_txn.size()), 32'h0);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready, "R1 reset idle", 32'(req_ready), 32'h1);
        check(!mg_valid, "R7 reset no transaction", 32'(mg_valid), 32'h0);
        check(!rsp_done && !rsp_err, "R9 reset outputs", {30'b0, rsp_done, rsp_err}, 32'h0);

        do_req(32'h0000_1234, 1'b1, 32'hCAFE_BEEF, 5'd31, -1, "R4 write basic");
        do_req(32'h0000_1234, 1'b0, 32'h0,         5'd31, -1, "R5 read basic");
        do_req(32'hABCD_0A4B, 1'b0, 32'h0,         5'd7,  -1, "R3 ignored addr bits read");
        do_req(32'h5A5A_0A4B, 1'b1, 32'h0102_0304, 5'd7,  -1, "R3 ignored addr bits write");
        do_req(32'h0000_FFFC, 1'b0, 32'h0,         5'd0,  -1, "R2 R3 max page and window");
        do_req(32'h0000_0000, 1'b1, 32'hFFFF_0000, 5'd12, -1, "R2 zero page");
        do_req(32'h0000_0840, 1'b1, 32'h1111_2222, 5'd3,   0, "R8 write error page step");
        do_req(32'h0000_0844, 1'b0, 32'h0,         5'd20,  1, "R8 read error low step");
        do_req(32'h0000_0848, 1'b1, 32'h3333_4444, 5'd23,  2, "R8 write error high step");
        do_req(32'h0000_0848, 1'b0, 32'h0,         5'd23,  2, "R8 read error high step");
        do_req(32'h0000_3FC0, 1'b0, 32'h0,         5'd28, -1, "R6 R9 read after error");
        do_req(32'h0000_C03C, 1'b1, 32'h8000_0001, 5'd15, -1, "R6 write other device");

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule